// File: doc/BRIEF.md
# Register Status and Rename Tracker

This block sits in the issue stage of a dynamically scheduled core. Instructions arrive one per cycle in program order. For each architectural register the block keeps one status entry. The entry is either zero, meaning the register file holds the newest value, or the number of the execution unit that will produce that value. The block looks up both source operands of an issuing instruction and reports, for each one, whether it can read the register file or which unit it must wait for. It also allots a free execution unit of the kind the instruction needs, and it retags the destination register with that unit's number.

When a unit finishes, it places its number and result on the common result bus. The block then frees that unit. It clears a status entry only if that entry still names the finishing unit, so an entry that a later writer has already retagged stays as it is. This gives register renaming and operand forwarding with a single table. A source that waits on a unit broadcasting in the same cycle is handed the value on the bus directly. When no suitable unit is free, the instruction stalls and the table is left untouched.

Top module: `rtk_rename_tracker`

## Requirements
- R1: An active-high synchronous reset sets every status entry to zero (register file valid), marks all units free, and drives `iss_grant`, `iss_stall`, `iss_unit_tag` and both operand outputs to zero.
- R2: A source whose status entry is zero is reported with operand tag 0, `fwd` 0 and value 0.
- R3: A source whose status entry holds unit tag t (t = unit index + 1, range 1..NUM_UNITS) is reported with operand tag t.
- R4: On a grant with `iss_has_dst`=1, the destination entry is overwritten with the allotted tag, even if an older producer is still pending. With `iss_has_dst`=0 no entry changes.
- R5: The allotted unit is the lowest-indexed unit that is set in both `iss_kind_mask` and the free vector. `iss_unit_tag` is that index plus 1, and the unit's bit in `unit_free` goes to 0.
- R6: If `iss_valid`=1 and no unit is both eligible and free, `iss_stall`=1 and `iss_grant`=0. No entry changes and no unit is taken.
- R7: A broadcast of tag t clears exactly the entries that hold t. An entry that holds a different tag is left unchanged.
- R8: A broadcast of tag t (1..NUM_UNITS) sets bit t-1 of `unit_free` from the next cycle.
- R9: If an issue writes register r in the same cycle as a broadcast that would clear r, the issue's new tag is kept.
- R10: A source whose entry holds the tag broadcast in the same cycle is reported with operand tag 0, `fwd`=1 and the bus data as its value.
- R11: Sources are looked up before the same instruction's destination update, so an instruction that reads its own destination sees the previous producer.
- R12: All issue results appear on registered outputs one clock after the inputs are sampled. They are zero in a cycle that follows no grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| iss_valid | input | 1 | An instruction is presented for issue |
| iss_src_a | input | REG_W | First source register index |
| iss_src_b | input | REG_W | Second source register index |
| iss_has_dst | input | 1 | Instruction writes a destination register |
| iss_dst | input | REG_W | Destination register index |
| iss_kind_mask | input | NUM_UNITS | Units able to execute this instruction |
| cdb_valid | input | 1 | Result broadcast present |
| cdb_tag | input | TAG_W | Number of the broadcasting unit |
| cdb_data | input | DATA_W | Broadcast result value |
| iss_grant | output | 1 | Previous cycle's instruction was issued |
| iss_stall | output | 1 | Previous cycle's instruction stalled |
| iss_unit_tag | output | TAG_W | Tag of the allotted unit |
| opa_tag | output | TAG_W | Producer tag for source A, 0 if ready |
| opa_fwd | output | 1 | Source A captured from the bus |
| opa_val | output | DATA_W | Captured value for source A |
| opb_tag | output | TAG_W | Producer tag for source B, 0 if ready |
| opb_fwd | output | 1 | Source B captured from the bus |
| opb_val | output | DATA_W | Captured value for source B |
| unit_free | output | NUM_UNITS | Free flag per execution unit |

## Verification
The bench uses the default parameters: 16 registers, 6 units, 3-bit tags and 32-bit data. With only six units, a few issues are enough to fill the pool, and a kind mask naming a single unit reaches the stall path in two instructions. With a 3-bit tag, every unit number and the reserved zero can be driven directly on the bus. This makes the same-cycle overlaps (a broadcast and a retag, and a broadcast and a lookup) cheap to reach.

// File: rtl/rtk_pkg.sv
package rtk_pkg;
  localparam int RTK_REGS   = 16;
  localparam int RTK_UNITS  = 6;
  localparam int RTK_DATA_W = 32;

  // tag width: one code per unit plus the reserved "ready" code 0
  function automatic int tag_bits(input int units);
    return $clog2(units + 1);
  endfunction
endpackage

// File: rtl/rtk_unit_alloc.sv
module rtk_unit_alloc #(
  parameter int NUM_UNITS = 6,
  parameter int TAG_W     = 3
) (
  input  logic [NUM_UNITS-1:0] cand,
  output logic                 found,
  output logic [TAG_W-1:0]     tag
);
  // lowest index wins: scan from the top so the last hit is the lowest
  always_comb begin
    found = |cand;
    tag   = '0;
    for (int i = NUM_UNITS - 1; i >= 0; i--) begin
      if (cand[i]) tag = TAG_W'(i + 1);
    end
  end
endmodule

// File: rtl/rtk_unit_pool.sv
module rtk_unit_pool #(
  parameter int NUM_UNITS = 6,
  parameter int TAG_W     = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 take_en,
  input  logic [TAG_W-1:0]     take_tag,
  input  logic                 rel_en,
  input  logic [TAG_W-1:0]     rel_tag,
  output logic [NUM_UNITS-1:0] free_q
);
  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    localparam logic [TAG_W-1:0] MY_TAG = TAG_W'(u + 1);
    always_ff @(posedge clk) begin
      if (rst)                                free_q[u] <= 1'b1;
      else if (take_en && take_tag == MY_TAG) free_q[u] <= 1'b0;
      else if (rel_en && rel_tag == MY_TAG)   free_q[u] <= 1'b1;
    end
  end
endmodule

// File: rtl/rtk_status_table.sv
module rtk_status_table #(
  parameter int NUM_REGS = 16,
  parameter int REG_W    = 4,
  parameter int TAG_W    = 3
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            wr_en,
  input  logic [REG_W-1:0]                wr_reg,
  input  logic [TAG_W-1:0]                wr_tag,
  input  logic                            clr_en,
  input  logic [TAG_W-1:0]                clr_tag,
  output logic [NUM_REGS-1:0][TAG_W-1:0]  entry_q
);
  // every entry compares against the bus tag at once, so the table is flops
  for (genvar r = 0; r < NUM_REGS; r++) begin : g_entry
    localparam logic [REG_W-1:0] MY_REG = REG_W'(r);
    always_ff @(posedge clk) begin
      if (rst)                                      entry_q[r] <= '0;
      else if (wr_en && wr_reg == MY_REG)           entry_q[r] <= wr_tag;
      else if (clr_en && entry_q[r] == clr_tag)     entry_q[r] <= '0;
    end
  end
endmodule

// File: rtl/rtk_src_lookup.sv
module rtk_src_lookup #(
  parameter int NUM_REGS = 16,
  parameter int REG_W    = 4,
  parameter int TAG_W    = 3,
  parameter int DATA_W   = 32
) (
  input  logic [NUM_REGS-1:0][TAG_W-1:0] entry_q,
  input  logic [REG_W-1:0]               sel,
  input  logic                           cdb_valid,
  input  logic [TAG_W-1:0]               cdb_tag,
  input  logic [DATA_W-1:0]              cdb_data,
  output logic [TAG_W-1:0]               tag,
  output logic                           fwd,
  output logic [DATA_W-1:0]              val
);
  logic [TAG_W-1:0] raw;
  logic             hit;

  always_comb begin
    raw = entry_q[sel];
    hit = cdb_valid && (raw != '0) && (raw == cdb_tag);
    tag = hit ? '0 : raw;
    fwd = hit;
    val = hit ? cdb_data : '0;
  end
endmodule

// File: rtl/rtk_rename_tracker.sv
module rtk_rename_tracker
  import rtk_pkg::*;
#(
  parameter int NUM_REGS  = RTK_REGS,
  parameter int NUM_UNITS = RTK_UNITS,
  parameter int DATA_W    = RTK_DATA_W,
  parameter int REG_W     = $clog2(NUM_REGS),
  parameter int TAG_W     = tag_bits(NUM_UNITS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 iss_valid,
  input  logic [REG_W-1:0]     iss_src_a,
  input  logic [REG_W-1:0]     iss_src_b,
  input  logic                 iss_has_dst,
  input  logic [REG_W-1:0]     iss_dst,
  input  logic [NUM_UNITS-1:0] iss_kind_mask,
  input  logic                 cdb_valid,
  input  logic [TAG_W-1:0]     cdb_tag,
  input  logic [DATA_W-1:0]    cdb_data,
  output logic                 iss_grant,
  output logic                 iss_stall,
  output logic [TAG_W-1:0]     iss_unit_tag,
  output logic [TAG_W-1:0]     opa_tag,
  output logic                 opa_fwd,
  output logic [DATA_W-1:0]    opa_val,
  output logic [TAG_W-1:0]     opb_tag,
  output logic                 opb_fwd,
  output logic [DATA_W-1:0]    opb_val,
  output logic [NUM_UNITS-1:0] unit_free
);
  logic [NUM_REGS-1:0][TAG_W-1:0] entry_q;
  logic [NUM_UNITS-1:0]           cand;
  logic                           found;
  logic [TAG_W-1:0]               alloc_tag;
  logic                           do_grant;
  logic                           bcast;
  logic [TAG_W-1:0]               a_tag, b_tag;
  logic                           a_fwd, b_fwd;
  logic [DATA_W-1:0]              a_val, b_val;

  assign cand     = iss_kind_mask & unit_free;
  assign do_grant = iss_valid && found;
  assign bcast    = cdb_valid && (cdb_tag != '0);

  rtk_unit_alloc #(.NUM_UNITS(NUM_UNITS), .TAG_W(TAG_W)) u_alloc (
    .cand(cand), .found(found), .tag(alloc_tag)
  );

  rtk_unit_pool #(.NUM_UNITS(NUM_UNITS), .TAG_W(TAG_W)) u_pool (
    .clk(clk), .rst(rst),
    .take_en(do_grant), .take_tag(alloc_tag),
    .rel_en(bcast), .rel_tag(cdb_tag),
    .free_q(unit_free)
  );

  rtk_status_table #(.NUM_REGS(NUM_REGS), .REG_W(REG_W), .TAG_W(TAG_W)) u_table (
    .clk(clk), .rst(rst),
    .wr_en(do_grant && iss_has_dst), .wr_reg(iss_dst), .wr_tag(alloc_tag),
    .clr_en(bcast), .clr_tag(cdb_tag),
    .entry_q(entry_q)
  );

  rtk_src_lookup #(.NUM_REGS(NUM_REGS), .REG_W(REG_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_look_a (
    .entry_q(entry_q), .sel(iss_src_a),
    .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_data(cdb_data),
    .tag(a_tag), .fwd(a_fwd), .val(a_val)
  );

  rtk_src_lookup #(.NUM_REGS(NUM_REGS), .REG_W(REG_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_look_b (
    .entry_q(entry_q), .sel(iss_src_b),
    .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_data(cdb_data),
    .tag(b_tag), .fwd(b_fwd), .val(b_val)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      iss_grant    <= 1'b0;
      iss_stall    <= 1'b0;
      iss_unit_tag <= '0;
      opa_tag      <= '0;
      opa_fwd      <= 1'b0;
      opa_val      <= '0;
      opb_tag      <= '0;
      opb_fwd      <= 1'b0;
      opb_val      <= '0;
    end else begin
      iss_grant    <= do_grant;
      iss_stall    <= iss_valid && !found;
      iss_unit_tag <= do_grant ? alloc_tag : '0;
      opa_tag      <= do_grant ? a_tag : '0;
      opa_fwd      <= do_grant && a_fwd;
      opa_val      <= do_grant ? a_val : '0;
      opb_tag      <= do_grant ? b_tag : '0;
      opb_fwd      <= do_grant && b_fwd;
      opb_val      <= do_grant ? b_val : '0;
    end
  end
endmodule

// File: rtl/rtk_tracker_chk.sv
module rtk_tracker_chk #(
  parameter int NUM_UNITS = 6,
  parameter int TAG_W     = 3
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 iss_valid,
  input logic [NUM_UNITS-1:0] iss_kind_mask,
  input logic                 cdb_valid,
  input logic [TAG_W-1:0]     cdb_tag,
  input logic                 iss_grant,
  input logic                 iss_stall,
  input logic [TAG_W-1:0]     iss_unit_tag,
  input logic [TAG_W-1:0]     opa_tag,
  input logic                 opa_fwd,
  input logic [NUM_UNITS-1:0] unit_free
);
  logic                 granted_free;
  logic [NUM_UNITS-1:0] cdb_onehot;

  always_comb begin
    granted_free = 1'b0;
    cdb_onehot   = '0;
    for (int i = 0; i < NUM_UNITS; i++) begin
      if (iss_unit_tag == TAG_W'(i + 1)) granted_free = unit_free[i];
      if (cdb_valid && cdb_tag == TAG_W'(i + 1)) cdb_onehot[i] = 1'b1;
    end
  end

  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (unit_free == '1 && !iss_grant && !iss_stall && iss_unit_tag == '0)); // R1

  AST_GRANT_STALL_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(iss_grant && iss_stall)); // R6

  AST_STALL_NO_UNIT: assert property (@(posedge clk) disable iff (rst)
    (iss_valid && (iss_kind_mask & unit_free) == '0) |=> (iss_stall && !iss_grant)); // R6

  AST_GRANT_WHEN_FREE: assert property (@(posedge clk) disable iff (rst)
    (iss_valid && (iss_kind_mask & unit_free) != '0) |=> (iss_grant && iss_unit_tag != '0)); // R5

  AST_GRANTED_UNIT_BUSY: assert property (@(posedge clk) disable iff (rst)
    iss_grant |-> !granted_free); // R5

  AST_BCAST_RELEASES: assert property (@(posedge clk) disable iff (rst)
    (cdb_onehot != '0 && !iss_valid) |=> ((unit_free & $past(cdb_onehot)) == $past(cdb_onehot))); // R8

  AST_FWD_MEANS_READY: assert property (@(posedge clk) disable iff (rst)
    opa_fwd |-> (opa_tag == '0)); // R10
endmodule

bind rtk_rename_tracker rtk_tracker_chk #(.NUM_UNITS(NUM_UNITS), .TAG_W(TAG_W)) u_chk (
  .clk(clk), .rst(rst), .iss_valid(iss_valid), .iss_kind_mask(iss_kind_mask),
  .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .iss_grant(iss_grant),
  .iss_stall(iss_stall), .iss_unit_tag(iss_unit_tag), .opa_tag(opa_tag),
  .opa_fwd(opa_fwd), .unit_free(unit_free)
);

// File: tb/test_rtk_rename_tracker.sv
module test_rtk_rename_tracker;
  localparam int NR = 16, NU = 6, DW = 32, RW = 4, TW = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic iss_valid = 0, iss_has_dst = 0, cdb_valid = 0;
  logic [RW-1:0] iss_src_a = 0, iss_src_b = 0, iss_dst = 0;
  logic [NU-1:0] iss_kind_mask = 0;
  logic [TW-1:0] cdb_tag = 0;
  logic [DW-1:0] cdb_data = 0;
  logic iss_grant, iss_stall, opa_fwd, opb_fwd;
  logic [TW-1:0] iss_unit_tag, opa_tag, opb_tag;
  logic [DW-1:0] opa_val, opb_val;
  logic [NU-1:0] unit_free;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;  // 50 MHz

  rtk_rename_tracker i_rtk_rename_tracker (
    .clk(clk), .rst(rst), .iss_valid(iss_valid), .iss_src_a(iss_src_a),
    .iss_src_b(iss_src_b), .iss_has_dst(iss_has_dst), .iss_dst(iss_dst),
    .iss_kind_mask(iss_kind_mask), .cdb_valid(cdb_valid), .cdb_tag(cdb_tag),
    .cdb_data(cdb_data), .iss_grant(iss_grant), .iss_stall(iss_stall),
    .iss_unit_tag(iss_unit_tag), .opa_tag(opa_tag), .opa_fwd(opa_fwd),
    .opa_val(opa_val), .opb_tag(opb_tag), .opb_fwd(opb_fwd), .opb_val(opb_val),
    .unit_free(unit_free)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // one clock: drive at falling edge, sample 2 ns after the rising edge
  task automatic step(input logic v, input logic [RW-1:0] a, input logic [RW-1:0] b,
                      input logic hd, input logic [RW-1:0] d, input logic [NU-1:0] km,
                      input logic cv, input logic [TW-1:0] ct, input logic [DW-1:0] cd);
    @(negedge clk);
    iss_valid = v; iss_src_a = a; iss_src_b = b; iss_has_dst = hd; iss_dst = d;
    iss_kind_mask = km; cdb_valid = cv; cdb_tag = ct; cdb_data = cd;
    @(posedge clk);
    #2;
  endtask

  task automatic issue(input logic [RW-1:0] a, input logic [RW-1:0] b, input logic [RW-1:0] d,
                       input logic [NU-1:0] km);
    step(1, a, b, 1, d, km, 0, 0, 0);
  endtask

  task automatic bcast(input logic [TW-1:0] t);
    step(0, 0, 0, 0, 0, 0, 1, t, 32'h0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; iss_valid = 0; cdb_valid = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 0;
    #1;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1", "unit_free", 32'(unit_free), 32'h3F);
    chk("R1", "grant", 32'(iss_grant), 0);
    chk("R1", "stall", 32'(iss_stall), 0);
    chk("R1", "unit_tag", 32'(iss_unit_tag), 0);
    chk("R1", "opa_tag", 32'(opa_tag), 0);
    issue(4'd1, 4'd2, 4'd3, 6'h3F);
    chk("R2", "opa_tag empty", 32'(opa_tag), 0);
    chk("R2", "opb_tag empty", 32'(opb_tag), 0);
    chk("R2", "opa_fwd", 32'(opa_fwd), 0);
  endtask

  task automatic t_retag();
    do_reset();
    issue(4'd2, 4'd3, 4'd1, 6'h3F);
    chk("R5", "first tag", 32'(iss_unit_tag), 1);
    chk("R5", "free after 1", 32'(unit_free), 32'h3E);
    issue(4'd1, 4'd5, 4'd4, 6'h3F);
    chk("R3", "src waits unit1", 32'(opa_tag), 1);
    chk("R5", "second tag", 32'(iss_unit_tag), 2);
    issue(4'd5, 4'd6, 4'd1, 6'h3F);
    chk("R5", "third tag", 32'(iss_unit_tag), 3);
    issue(4'd1, 4'd4, 4'd7, 6'h3F);
    chk("R4", "r1 retagged", 32'(opa_tag), 3);
    chk("R3", "r4 waits unit2", 32'(opb_tag), 2);
    step(1, 4'd0, 4'd0, 0, 4'd2, 6'h3F, 0, 0, 0);
    chk("R12", "grant no dst", 32'(iss_grant), 1);
    issue(4'd2, 4'd0, 4'd8, 6'h3F);
    chk("R4", "no dst leaves r2", 32'(opa_tag), 0);
  endtask

  task automatic t_release();
    do_reset();
    issue(4'd0, 4'd0, 4'd1, 6'h3F);  // r1 <- unit1
    issue(4'd0, 4'd0, 4'd1, 6'h3F);  // r1 <- unit2
    bcast(3'd1);
    chk("R8", "unit1 freed", 32'(unit_free), 32'h3D);
    chk("R12", "idle grant", 32'(iss_grant), 0);
    issue(4'd1, 4'd0, 4'd9, 6'h02);  // only unit2 eligible, busy -> stall
    chk("R6", "stall busy", 32'(iss_stall), 1);
    issue(4'd1, 4'd0, 4'd9, 6'h3F);
    chk("R7", "stale bcast keeps r1", 32'(opa_tag), 2);
    bcast(3'd2);
    issue(4'd1, 4'd9, 4'd10, 6'h3F);
    chk("R7", "current bcast clears r1", 32'(opa_tag), 0);
    chk("R3", "r9 waits unit1", 32'(opb_tag), 1);
  endtask

  task automatic t_stall();
    do_reset();
    issue(4'd0, 4'd0, 4'd1, 6'h01);
    chk("R5", "single kind", 32'(iss_unit_tag), 1);
    issue(4'd1, 4'd0, 4'd2, 6'h01);
    chk("R6", "stall", 32'(iss_stall), 1);
    chk("R6", "no grant", 32'(iss_grant), 0);
    chk("R6", "free unchanged", 32'(unit_free), 32'h3E);
    issue(4'd2, 4'd1, 4'd3, 6'h02);
    chk("R6", "r2 untouched", 32'(opa_tag), 0);
    chk("R3", "r1 waits", 32'(opb_tag), 1);
    chk("R5", "unit2", 32'(iss_unit_tag), 2);
    issue(4'd0, 4'd0, 4'd4, 6'b101100);
    chk("R5", "lowest eligible", 32'(iss_unit_tag), 3);
  endtask

  task automatic t_same_cycle();
    do_reset();
    issue(4'd0, 4'd0, 4'd5, 6'h3F);             // r5 <- unit1
    step(1, 4'd0, 4'd0, 1, 4'd5, 6'h3F, 1, 3'd1, 32'h11);
    chk("R9", "new tag", 32'(iss_unit_tag), 2);
    issue(4'd5, 4'd0, 4'd6, 6'h3F);
    chk("R9", "issue beats clear", 32'(opa_tag), 2);
    do_reset();
    issue(4'd0, 4'd0, 4'd3, 6'h3F);             // r3 <- unit1
    step(1, 4'd3, 4'd4, 1, 4'd7, 6'h3F, 1, 3'd1, 32'hDEADBEEF);
    chk("R10", "fwd a", 32'(opa_fwd), 1);
    chk("R10", "val a", opa_val, 32'hDEADBEEF);
    chk("R10", "tag a", 32'(opa_tag), 0);
    chk("R10", "fwd b", 32'(opb_fwd), 0);
    do_reset();
    issue(4'd6, 4'd0, 4'd6, 6'h3F);
    chk("R11", "own dst first", 32'(opa_tag), 0);
    issue(4'd6, 4'd0, 4'd6, 6'h3F);
    chk("R11", "own dst old producer", 32'(opa_tag), 1);
    chk("R11", "new unit", 32'(iss_unit_tag), 2);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    t_reset();
    t_retag();
    t_release();
    t_stall();
    t_same_cycle();
    done = 1;
    summary();
    $finish;
  end
endmodule